// File: doc/BRIEF.md
# Legacy Divisor Fallback Register Block

This block holds the mode state of an enhanced serial/infrared controller and decodes processor accesses to its baud divisor. Two pairs of ports reach the 16-bit divisor. The legacy pair sits in bank 1, and any read or write through it forces the controller back towards plain legacy-UART behaviour. The modern pair sits in bank 2 and changes the divisor with no side effect. Software running in the enhanced modes uses the bank-2 pair. Old software that knows only the legacy pair falls back to a known compatible state without any help.

A fallback always restores the 16-entry FIFO depth, loads 13 into the prescaler and clears both test bits. If the controller was in extended mode, it also leaves extended mode, and a consumer-IR or UART selection becomes UART. The serial-IR and sharp-IR selections are kept. In non-extended mode a lock bit turns the legacy pair into two scratch bytes. Legacy software can then run at any rate the bank-2 pair has set, without changing it.

Top module: `fbk_top`

## Requirements
- R1: After reset the bank is 0, the config byte is 0x00 (non-extended, UART, unlocked, 16-entry FIFO, test bits clear), the prescaler is 13, the divisor is 0x000C, both scratch bytes are 0 and `fallback_evt` is low.
- R2: Address 7 selects the bank in every bank. A write stores wdata[1:0], and a read returns {6'b0, bank}.
- R3: In bank 0, address 0 is the config byte: bit0 extended, bits[2:1] mode (0 UART, 1 serial-IR, 2 sharp-IR, 3 consumer-IR), bit3 lock, bit4 FIFO deep (1 = 32 entries), bit5 loop test, bit6 diag test. Bit7 reads 0. Address 1 is the 8-bit prescaler.
- R4: In bank 2, address 0 reads and writes divisor[7:0] and address 1 reads and writes divisor[15:8]. Such an access never raises a fallback.
- R5: In bank 1 with fallback enabled, a read or a write to address 0 or 1 triggers a fallback. A write also stores the divisor byte, and a read returns the divisor byte.
- R6: A fallback clears the FIFO-deep bit and both test bits and sets the prescaler to 13.
- R7: A fallback from extended mode clears the extended bit and turns mode 0 or 3 into mode 0.
- R8: A fallback keeps mode 1 or 2 unchanged.
- R9: A fallback from non-extended mode leaves the mode field and the extended bit unchanged.
- R10: In extended mode the lock bit has no effect, and bank-1 divisor accesses always fall back.
- R11: With lock set in non-extended mode, bank-1 addresses 0 and 1 read and write two scratch bytes. The divisor, the config byte and the prescaler do not change, and no fallback occurs.
- R12: `fallback_evt` is high for exactly the one cycle after the access that triggered a fallback.
- R13: Addresses 2 to 6 in any bank, and addresses 0 and 1 in bank 3, read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Port address within the bank |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data (combinational, current state) |
| divisor | output | 16 | Baud divisor |
| prescale | output | 8 | Prescaler value |
| fifo_deep | output | 1 | 1 = 32-entry FIFOs, 0 = 16 |
| test_loop | output | 1 | Loop test bit |
| test_diag | output | 1 | Diagnostic test bit |
| op_mode | output | 2 | Operating mode |
| ext_mode | output | 1 | Extended-mode flag |
| lock | output | 1 | Lock bit |
| fallback_evt | output | 1 | One-cycle fallback indication |

## Verification
Assertions check on every cycle that bank-2 and locked accesses raise no fallback, and that a locked legacy access leaves the divisor alone. They also check the state after every fallback: the FIFO depth, the prescaler and the test bits, the extended-bit and mode outcome for each starting mode, and the one-cycle event. Only the bench scenarios can show the read data on each port, that a scratch value comes back after the lock is dropped and set again, the exact reset values, and that unmapped writes have no effect on any visible state.

// File: rtl/fbk_pkg.sv
package fbk_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int BANK_W    = 2;
    localparam int DIV_W     = 2 * DATA_W;
    localparam logic [1:0] MODE_UART  = 2'd0;
    localparam logic [1:0] MODE_SIR   = 2'd1;
    localparam logic [1:0] MODE_SHARP = 2'd2;
    localparam logic [1:0] MODE_CIR   = 2'd3;

    typedef struct packed {
        logic       test_diag;
        logic       test_loop;
        logic       fifo_deep;
        logic       lock;
        logic [1:0] op_mode;
        logic       ext;
    } mode_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_BANK,
        ACC_CFG,
        ACC_PRE,
        ACC_LEGDIV,
        ACC_SCRATCH,
        ACC_NEWDIV,
        ACC_UNMAP
    } acc_kind_e;
endpackage

// File: rtl/fbk_decode.sv
module fbk_decode
    import fbk_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BANK_W
) (
    input  logic          acc_en,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] bank,
    input  logic          ext,
    input  logic          lock,
    output acc_kind_e     kind,
    output logic          hi_byte
);
    localparam logic [AW-1:0] BANK_ADDR = AW'((1 << AW) - 1);

    always_comb begin
        kind    = ACC_NONE;
        hi_byte = addr[0];
        if (acc_en) begin
            kind = ACC_UNMAP;
            if (addr == BANK_ADDR) begin
                kind = ACC_BANK;
            end else if (addr < AW'(2)) begin
                case (bank)
                    BW'(0): kind = addr[0] ? ACC_PRE : ACC_CFG;
                    BW'(1): kind = (lock && !ext) ? ACC_SCRATCH : ACC_LEGDIV;
                    BW'(2): kind = ACC_NEWDIV;
                    default: kind = ACC_UNMAP;
                endcase
            end
        end
    end
endmodule

// File: rtl/fbk_fallback.sv
module fbk_fallback
    import fbk_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter logic [DW-1:0] PRESCALE_DEFAULT = DW'(13)
) (
    input  mode_t         cur,
    output mode_t         nxt,
    output logic [DW-1:0] prescale
);
    always_comb begin
        nxt           = cur;
        nxt.fifo_deep = 1'b0;
        nxt.test_loop = 1'b0;
        nxt.test_diag = 1'b0;
        prescale      = PRESCALE_DEFAULT;
        if (cur.ext) begin
            nxt.ext = 1'b0;
            if (cur.op_mode != MODE_SIR && cur.op_mode != MODE_SHARP) begin
                nxt.op_mode = MODE_UART;
            end
        end
    end
endmodule

// File: rtl/fbk_top.sv
module fbk_top
    import fbk_pkg::*;
#(
    parameter int              DW           = DATA_W,
    parameter int              AW           = ADDR_W,
    parameter logic [2*DW-1:0] DIV_RESET    = 16'h000C,
    parameter logic [DW-1:0]   PRESCALE_DEF = 8'd13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_en,
    input  logic            acc_wr,
    input  logic [AW-1:0]   acc_addr,
    input  logic [DW-1:0]   acc_wdata,
    output logic [DW-1:0]   acc_rdata,
    output logic [2*DW-1:0] divisor,
    output logic [DW-1:0]   prescale,
    output logic            fifo_deep,
    output logic            test_loop,
    output logic            test_diag,
    output logic [1:0]      op_mode,
    output logic            ext_mode,
    output logic            lock,
    output logic            fallback_evt
);
    localparam int CFG_W = $bits(mode_t);

    typedef struct packed {
        mode_t               mode;
        logic [BANK_W-1:0]   bank;
        logic [2*DW-1:0]     div;
        logic [DW-1:0]       pre;
        logic [DW-1:0]       scr_lo;
        logic [DW-1:0]       scr_hi;
        logic                fb_evt;
    } state_t;

    state_t    st_q, st_d;
    acc_kind_e kind;
    logic      hi_byte;
    mode_t     fb_mode;
    logic [DW-1:0] fb_pre;

    fbk_decode #(.AW(AW), .BW(BANK_W)) u_dec (
        .acc_en (acc_en),
        .addr   (acc_addr),
        .bank   (st_q.bank),
        .ext    (st_q.mode.ext),
        .lock   (st_q.mode.lock),
        .kind   (kind),
        .hi_byte(hi_byte)
    );

    fbk_fallback #(.DW(DW), .PRESCALE_DEFAULT(PRESCALE_DEF)) u_fb (
        .cur     (st_q.mode),
        .nxt     (fb_mode),
        .prescale(fb_pre)
    );

    // read path, from current state
    always_comb begin
        acc_rdata = '0;
        case (kind)
            ACC_BANK:    acc_rdata = DW'(st_q.bank);
            ACC_CFG:     acc_rdata = DW'(st_q.mode);
            ACC_PRE:     acc_rdata = st_q.pre;
            ACC_LEGDIV,
            ACC_NEWDIV:  acc_rdata = hi_byte ? st_q.div[2*DW-1:DW] : st_q.div[DW-1:0];
            ACC_SCRATCH: acc_rdata = hi_byte ? st_q.scr_hi : st_q.scr_lo;
            default:     acc_rdata = '0;
        endcase
    end

    // next state
    always_comb begin
        st_d        = st_q;
        st_d.fb_evt = 1'b0;
        case (kind)
            ACC_BANK: if (acc_wr) st_d.bank = acc_wdata[BANK_W-1:0];
            ACC_CFG:  if (acc_wr) st_d.mode = mode_t'(acc_wdata[CFG_W-1:0]);
            ACC_PRE:  if (acc_wr) st_d.pre = acc_wdata;
            ACC_NEWDIV: begin
                if (acc_wr) begin
                    if (hi_byte) st_d.div[2*DW-1:DW] = acc_wdata;
                    else         st_d.div[DW-1:0]    = acc_wdata;
                end
            end
            ACC_LEGDIV: begin
                if (acc_wr) begin
                    if (hi_byte) st_d.div[2*DW-1:DW] = acc_wdata;
                    else         st_d.div[DW-1:0]    = acc_wdata;
                end
                st_d.mode   = fb_mode;
                st_d.pre    = fb_pre;
                st_d.fb_evt = 1'b1;
            end
            ACC_SCRATCH: begin
                if (acc_wr) begin
                    if (hi_byte) st_d.scr_hi = acc_wdata;
                    else         st_d.scr_lo = acc_wdata;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.div    <= DIV_RESET;
            st_q.pre    <= PRESCALE_DEF;
        end else begin
            st_q <= st_d;
        end
    end

    assign divisor      = st_q.div;
    assign prescale     = st_q.pre;
    assign fifo_deep    = st_q.mode.fifo_deep;
    assign test_loop    = st_q.mode.test_loop;
    assign test_diag    = st_q.mode.test_diag;
    assign op_mode      = st_q.mode.op_mode;
    assign ext_mode     = st_q.mode.ext;
    assign lock         = st_q.mode.lock;
    assign fallback_evt = st_q.fb_evt;

    // bank-2 divisor access never falls back
    assert_bank2_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_addr < AW'(2) && st_q.bank == BANK_W'(2)) |=> !fallback_evt);

    // common fallback actions
    assert_fb_common_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fallback_evt |-> (!fifo_deep && !test_loop && !test_diag && prescale == PRESCALE_DEF));

    // extended fallback leaves extended mode, no consumer-IR survives
    assert_fb_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_addr < AW'(2) && st_q.bank == BANK_W'(1) && ext_mode)
        |=> (!ext_mode && op_mode != MODE_CIR && fallback_evt));

    // infrared modes are retained
    assert_fb_ir_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_addr < AW'(2) && st_q.bank == BANK_W'(1) && ext_mode
         && (op_mode == MODE_SIR || op_mode == MODE_SHARP)) |=> $stable(op_mode));

    // non-extended fallback leaves mode and extended flag alone
    assert_fb_plain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_addr < AW'(2) && st_q.bank == BANK_W'(1) && !ext_mode)
        |=> ($stable(op_mode) && !ext_mode));

    // locked legacy access touches neither divisor nor mode
    assert_lock_overlay_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_addr < AW'(2) && st_q.bank == BANK_W'(1) && !ext_mode && lock)
        |=> ($stable(divisor) && $stable(prescale) && !fallback_evt && lock));

    // event lasts one cycle
    assert_evt_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (fallback_evt && !(acc_en && acc_addr < AW'(2) && st_q.bank == BANK_W'(1)))
        |=> !fallback_evt);
endmodule

// File: tb/fbk_top_tb.sv
module fbk_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0;
    logic [2:0]  acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic [15:0] divisor;
    logic [7:0]  prescale;
    logic        fifo_deep, test_loop, test_diag, ext_mode, lock, fallback_evt;
    logic [1:0]  op_mode;

    int vectors = 0;
    int miscompares = 0;

    // bench model
    logic [1:0]  m_bank;
    logic [6:0]  m_cfg;
    logic [7:0]  m_pre, m_slo, m_shi;
    logic [15:0] m_div;
    logic        m_evt;

    fbk_top u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .divisor(divisor), .prescale(prescale), .fifo_deep(fifo_deep),
        .test_loop(test_loop), .test_diag(test_diag), .op_mode(op_mode),
        .ext_mode(ext_mode), .lock(lock), .fallback_evt(fallback_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] fb_cfg(input logic [6:0] c);
        logic [6:0] r;
        r = c;
        r[4] = 1'b0; r[5] = 1'b0; r[6] = 1'b0;
        if (c[0]) begin
            r[0] = 1'b0;
            if (c[2:1] == 2'd0 || c[2:1] == 2'd3) r[2:1] = 2'd0;
        end
        return r;
    endfunction

    function automatic string kind_tag(input logic [2:0] a);
        if (a == 3'd7) return "R2";
        if (a > 3'd1 || m_bank == 2'd3) return "R13";
        if (m_bank == 2'd0) return "R3";
        if (m_bank == 2'd2) return "R4";
        if (m_cfg[3] && !m_cfg[0]) return "R11";
        if (m_cfg[0]) return m_cfg[3] ? "R10" : "R7";
        return "R9";
    endfunction

    task automatic check_outs(input string req);
        chk(req, "divisor", int'(divisor), int'(m_div));
        chk(req, "prescale", int'(prescale), int'(m_pre));
        chk(req, "cfg", int'({test_diag, test_loop, fifo_deep, lock, op_mode, ext_mode}), int'(m_cfg));
        chk("R12", "fallback_evt", int'(fallback_evt), int'(m_evt));
    endtask

    task automatic do_op(input logic wr, input logic [2:0] a, input logic [7:0] d);
        string tag;
        logic [7:0] exp_rd;
        tag = kind_tag(a);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = d;
        exp_rd = 8'h00;
        m_evt = 1'b0;
        if (a == 3'd7) begin
            exp_rd = {6'b0, m_bank};
            if (wr) m_bank = d[1:0];
        end else if (a <= 3'd1) begin
            case (m_bank)
                2'd0: begin
                    exp_rd = a[0] ? m_pre : {1'b0, m_cfg};
                    if (wr) begin
                        if (a[0]) m_pre = d; else m_cfg = d[6:0];
                    end
                end
                2'd1: begin
                    if (m_cfg[3] && !m_cfg[0]) begin
                        exp_rd = a[0] ? m_shi : m_slo;
                        if (wr) begin
                            if (a[0]) m_shi = d; else m_slo = d;
                        end
                    end else begin
                        exp_rd = a[0] ? m_div[15:8] : m_div[7:0];
                        if (wr) begin
                            if (a[0]) m_div[15:8] = d; else m_div[7:0] = d;
                        end
                        m_cfg = fb_cfg(m_cfg);
                        m_pre = 8'd13;
                        m_evt = 1'b1;
                    end
                end
                2'd2: begin
                    exp_rd = a[0] ? m_div[15:8] : m_div[7:0];
                    if (wr) begin
                        if (a[0]) m_div[15:8] = d; else m_div[7:0] = d;
                    end
                end
                default: exp_rd = 8'h00;
            endcase
        end
        #1;
        if (!wr) chk(tag, "rdata", int'(acc_rdata), int'(exp_rd));
        @(negedge clk);
        acc_en = 1'b0;
        check_outs(tag);
        // event must drop after an idle cycle
        @(negedge clk);
        m_evt = 1'b0;
        chk("R12", "evt_drop", int'(fallback_evt), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_bank = 2'd0; m_cfg = 7'd0; m_pre = 8'd13; m_div = 16'h000C;
        m_slo = 8'd0; m_shi = 8'd0; m_evt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outs("R1");

        // R2 bank select and readback
        do_op(1'b1, 3'd7, 8'hFE);
        do_op(1'b0, 3'd7, 8'h00);
        do_op(1'b1, 3'd7, 8'h00);
        // R3 config and prescaler
        do_op(1'b1, 3'd0, 8'hFF);
        do_op(1'b0, 3'd0, 8'h00);
        do_op(1'b1, 3'd1, 8'h22);
        do_op(1'b0, 3'd1, 8'h00);
        // R4 bank-2 divisor writes, no fallback
        do_op(1'b1, 3'd7, 8'h02);
        do_op(1'b1, 3'd0, 8'h34);
        do_op(1'b1, 3'd1, 8'h12);
        do_op(1'b0, 3'd1, 8'h00);
        // R10: ext + lock + consumer-IR, legacy read falls back to UART (R7)
        do_op(1'b1, 3'd7, 8'h00);
        do_op(1'b1, 3'd0, 8'h7F);
        do_op(1'b1, 3'd7, 8'h01);
        do_op(1'b0, 3'd0, 8'h00);
        // R11: non-ext + lock, scratch overlay
        do_op(1'b1, 3'd0, 8'h5A);
        do_op(1'b1, 3'd1, 8'hA5);
        do_op(1'b0, 3'd0, 8'h00);
        do_op(1'b0, 3'd1, 8'h00);
        // R8: ext + sharp-IR keeps mode
        do_op(1'b1, 3'd7, 8'h00);
        do_op(1'b1, 3'd0, 8'h75);
        do_op(1'b1, 3'd7, 8'h01);
        do_op(1'b1, 3'd1, 8'h09);
        // R9/R5: non-ext unlocked with serial-IR, legacy write
        do_op(1'b1, 3'd7, 8'h00);
        do_op(1'b1, 3'd0, 8'h72);
        do_op(1'b1, 3'd7, 8'h01);
        do_op(1'b1, 3'd0, 8'h44);
        // R13 unmapped
        do_op(1'b1, 3'd4, 8'hFF);
        do_op(1'b0, 3'd5, 8'h00);
        do_op(1'b1, 3'd7, 8'h03);
        do_op(1'b1, 3'd0, 8'hEE);
        do_op(1'b0, 3'd1, 8'h00);

        // constrained random mix
        for (int i = 0; i < 1500; i++) begin
            int r;
            logic [2:0] a;
            r = int'($urandom % 100);
            if (r < 15)      a = 3'd7;
            else if (r < 90) a = 3'($urandom % 2);
            else             a = 3'($urandom % 8);
            do_op(1'($urandom % 2), a, 8'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule